// File: doc/BRIEF.md
# Toggle Pulse Synchronizer

This block moves single-cycle event pulses from one clock domain into another clock domain whose frequency and phase have no fixed relation to the first. Each input pulse inverts a level register in the source domain, so every event becomes exactly one change of level. That level crosses into the destination domain through a chain of synchronizing flip-flops. A registered comparison of the two most recent synchronized samples then rebuilds the event as a pulse one destination clock long.

The allowed input rate depends on the ratio of the two clocks. When the destination clock is faster than the source clock, the input may stay high on every source cycle and every cycle still counts as one event. When the source clock runs n times as fast as the destination clock, events must be at least n source cycles apart, and faster input may lose events. The two frequencies need no other relation. Each domain has its own asynchronous active-low reset, which is expected to be already released in step with that domain's clock.

Top module: `pulse_xing`

## Requirements
- R1: While `dst_rst_n` is low, `dst_pulse` is low. After both resets are released and no source event has occurred, `dst_pulse` stays low.
- R2: The number of destination cycles in which `dst_pulse` is high equals the number of source cycles in which `src_pulse` was sampled high, provided the rate rules in R5 and R6 are respected.
- R3: A single isolated source event gives a `dst_pulse` that is high for exactly one destination cycle.
- R4: For an isolated event, `dst_pulse` rises between S and S+2 destination rising edges after the source edge that samples the event. S is the chain depth, `max(2, SYNC_STAGES)`.
- R5: When the destination clock is faster, holding `src_pulse` high for K consecutive source cycles gives exactly K destination high cycles.
- R6: When the source clock is n times as fast, events spaced at least ceil(n) source cycles apart are all delivered, with regular or irregular spacing.
- R7: Resetting both domains together after an odd number of events produces no `dst_pulse` after the resets are released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain asynchronous reset, active low |
| src_pulse | input | 1 | Event input; one high source cycle is one event |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain asynchronous reset, active low |
| dst_pulse | output | 1 | Rebuilt event; one high destination cycle per event |

## Verification
Any fault in the source level register or in the synchronizing chain shows up at the port as a missing, extra or doubled destination pulse. This happens within S+2 destination cycles of the source edge involved, so the checks compare event counts on both sides after each scenario has settled. A fault in the history register shows up as a pulse wider than one cycle, or as a pulse right after reset. For this reason the bench measures pulse width, measures latency against the chain depth, and watches for a quiet output after a reset taken mid-stream. The checker adds a parity relation: the number of output pulses is related to the last level seen in the destination domain, and this catches a divergence on the cycle it happens.

// File: rtl/pulse_xing_pkg.sv
package pulse_xing_pkg;

  // Smallest chain depth that still gives a settled level at the output.
  localparam int unsigned MIN_SYNC_STAGES = 2;

  // Chain depth actually built for a requested depth.
  function automatic int unsigned chain_depth(input int unsigned requested);
    return (requested < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : requested;
  endfunction

endpackage

// File: rtl/pulse_xing_src_toggle.sv
module pulse_xing_src_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  output logic level_o
);

  logic level_q;
  logic level_d;

  // Each sampled event inverts the level. The pulse acts as the clock enable.
  always_comb begin
    if (pulse_i) begin
      level_d = ~level_q;
    end else begin
      level_d = level_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b0;
    end else begin
      level_q <= level_d;
    end
  end

  assign level_o = level_q;

endmodule

// File: rtl/pulse_xing_sync_chain.sv
module pulse_xing_sync_chain #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      // The first stage is the only one that sees the foreign-domain level.
      always_comb stage_d[g] = async_i;
    end else begin : g_next
      always_comb stage_d[g] = stage_q[g-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[g] <= 1'b0;
      end else begin
        stage_q[g] <= stage_d[g];
      end
    end
  end

  assign level_o = stage_q[STAGES-1];

endmodule

// File: rtl/pulse_xing_edge_rebuild.sv
module pulse_xing_edge_rebuild (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic pulse_o,
  output logic hist_o
);

  logic hist_q;
  logic hist_d;
  logic pulse_q;
  logic pulse_d;

  always_comb begin
    hist_d  = level_i;
    // A level change between two consecutive samples is one event.
    pulse_d = level_i ^ hist_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      hist_q  <= hist_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;
  assign hist_o  = hist_q;

endmodule

// File: rtl/pulse_xing.sv
module pulse_xing #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic src_pulse,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic dst_pulse
);

  import pulse_xing_pkg::*;

  localparam int unsigned CHAIN = chain_depth(SYNC_STAGES);

  logic src_level;
  logic dst_level;
  logic dst_hist;

  pulse_xing_src_toggle u_src (
    .clk_i   (src_clk),
    .rst_ni  (src_rst_n),
    .pulse_i (src_pulse),
    .level_o (src_level)
  );

  pulse_xing_sync_chain #(
    .STAGES (CHAIN)
  ) u_chain (
    .clk_i   (dst_clk),
    .rst_ni  (dst_rst_n),
    .async_i (src_level),
    .level_o (dst_level)
  );

  pulse_xing_edge_rebuild u_edge (
    .clk_i   (dst_clk),
    .rst_ni  (dst_rst_n),
    .level_i (dst_level),
    .pulse_o (dst_pulse),
    .hist_o  (dst_hist)
  );

endmodule

// File: rtl/pulse_xing_chk.sv
module pulse_xing_chk (
  input logic src_clk,
  input logic src_rst_n,
  input logic src_pulse,
  input logic src_level,
  input logic dst_clk,
  input logic dst_rst_n,
  input logic dst_pulse,
  input logic dst_hist
);

  // Parity of the output pulses seen since the destination reset.
  logic out_par_q;

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      out_par_q <= 1'b0;
    end else if (dst_pulse) begin
      out_par_q <= ~out_par_q;
    end
  end

  // R2
  level_flip_chk: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    src_pulse |=> (src_level != $past(src_level)));

  // R2
  level_hold_chk: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    !src_pulse |=> $stable(src_level));

  // R1
  reset_quiet_chk: assert property (@(posedge dst_clk)
    !dst_rst_n |=> !dst_pulse);

  // R2
  pulse_parity_chk: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    (out_par_q ^ dst_pulse) == dst_hist);

endmodule

bind pulse_xing pulse_xing_chk u_chk (
  .src_clk   (src_clk),
  .src_rst_n (src_rst_n),
  .src_pulse (src_pulse),
  .src_level (src_level),
  .dst_clk   (dst_clk),
  .dst_rst_n (dst_rst_n),
  .dst_pulse (dst_pulse),
  .dst_hist  (dst_hist)
);

// File: tb/pulse_xing_test.sv
`timescale 1ns/1ps
module pulse_xing_test;

  localparam int STG = 3;
  localparam real DST_HALF = 2.5;

  logic src_clk = 1'b0;
  logic dst_clk = 1'b0;
  logic src_rst_n = 1'b0;
  logic dst_rst_n = 1'b0;
  logic src_pulse = 1'b0;
  logic dst_pulse;

  real src_half = 6.5;
  int  checks = 0;
  int  fails = 0;
  int  dst_cnt = 0;
  int  src_cnt = 0;
  bit  done = 1'b0;

  pulse_xing #(.SYNC_STAGES(STG)) uut (
    .src_clk   (src_clk),
    .src_rst_n (src_rst_n),
    .src_pulse (src_pulse),
    .dst_clk   (dst_clk),
    .dst_rst_n (dst_rst_n),
    .dst_pulse (dst_pulse)
  );

  always #(DST_HALF) dst_clk = ~dst_clk;
  always #(src_half) src_clk = ~src_clk;

  always @(negedge dst_clk) if (dst_rst_n && dst_pulse) dst_cnt++;
  always @(negedge src_clk) if (src_rst_n && src_pulse) src_cnt++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic dst_wait(input int n);
    for (int i = 0; i < n; i++) @(negedge dst_clk);
  endtask

  task automatic t_reset();
    int high = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge dst_clk);
      if (dst_pulse) high++;
    end
    check(high == 0, "R1 low during reset", high, 0);
    @(negedge src_clk); src_rst_n = 1'b1;
    @(negedge dst_clk); dst_rst_n = 1'b1;
    dst_wait(20);
    check(dst_cnt == 0, "R1 quiet after release", dst_cnt, 0);
  endtask

  task automatic t_single(input real half);
    int base;
    int k = 0;
    int w = 1;
    src_half = half;
    dst_wait(10);
    base = dst_cnt;
    @(negedge src_clk); src_pulse = 1'b1;
    @(posedge src_clk);
    fork begin @(negedge src_clk); src_pulse = 1'b0; end join_none
    for (int i = 0; i < 40; i++) begin
      @(posedge dst_clk); #1;
      k++;
      if (dst_pulse) break;
    end
    for (int i = 0; i < 10; i++) begin
      @(posedge dst_clk); #1;
      if (dst_pulse) w++; else break;
    end
    check(k >= STG && k <= STG + 2, "R4 latency", k, STG + 1);
    check(w == 1, "R3 width", w, 1);
    dst_wait(10);
    check(dst_cnt - base == 1, "R2 one event", dst_cnt - base, 1);
  endtask

  task automatic t_burst(input int len);
    int base_d;
    int base_s;
    src_half = 6.5;
    dst_wait(10);
    base_d = dst_cnt;
    base_s = src_cnt;
    @(negedge src_clk); src_pulse = 1'b1;
    for (int i = 0; i < len; i++) @(negedge src_clk);
    src_pulse = 1'b0;
    dst_wait(STG + 10);
    check(src_cnt - base_s == len, "R5 source events", src_cnt - base_s, len);
    check(dst_cnt - base_d == len, "R5 held input", dst_cnt - base_d, len);
  endtask

  task automatic t_slow(input int num, input bit irregular);
    int base;
    int gap;
    src_half = 1.0;
    dst_wait(10);
    base = dst_cnt;
    for (int i = 0; i < num; i++) begin
      @(negedge src_clk); src_pulse = 1'b1;
      @(negedge src_clk); src_pulse = 1'b0;
      gap = (irregular && (i % 2 == 1)) ? 3 : 2;
      for (int j = 0; j < gap; j++) @(negedge src_clk);
    end
    dst_wait(STG + 10);
    check(dst_cnt - base == num, irregular ? "R6 irregular spacing" : "R6 spacing 3",
          dst_cnt - base, num);
  endtask

  task automatic t_midreset();
    int base;
    int high = 0;
    src_half = 6.5;
    dst_wait(10);
    base = dst_cnt;
    @(negedge src_clk); src_pulse = 1'b1;
    @(negedge src_clk); src_pulse = 1'b0;
    if (((src_cnt) % 2) == 0) begin
      @(negedge src_clk); src_pulse = 1'b1;
      @(negedge src_clk); src_pulse = 1'b0;
    end
    dst_wait(STG + 10);
    check(dst_cnt - base >= 1, "R2 delivered before reset", dst_cnt - base, 1);
    #0.3;
    src_rst_n = 1'b0;
    dst_rst_n = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge dst_clk);
      if (dst_pulse) high++;
    end
    check(high == 0, "R1 low during mid reset", high, 0);
    @(negedge src_clk); src_rst_n = 1'b1;
    @(negedge dst_clk); dst_rst_n = 1'b1;
    base = dst_cnt;
    dst_wait(25);
    check(dst_cnt == base, "R7 no spurious pulse", dst_cnt - base, 0);
  endtask

  initial begin
    #500000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_single(6.5);
    t_single(8.5);
    t_single(11.5);
    t_burst(20);
    t_slow(30, 1'b0);
    t_slow(25, 1'b1);
    t_midreset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule